// File: doc/BRIEF.md
# Page-write load controller

This block is the write front end of a byte-wide nonvolatile memory model. A host writes bytes over a parallel bus with select, write and read strobes. The first byte of a load fixes the page, which is the upper address bits. Each byte is held in a page-sized load buffer at its in-page offset. Every write strobe restarts a byte-load window. When a whole window passes with no new strobe, the block enters a programming phase of fixed length. During that phase it reports busy and copies every loaded offset of the buffer into a synchronous storage array. A read request returns one array byte on a registered output.

A page holds 256 bytes. The low 8 address bits select the byte within the page, and the remaining upper bits select the page. The default array is small, with 8 pages and an 11-bit address. Setting `ADDR_W` to 17 gives the full 128K-byte space. The window length and the programming length are parameters counted in clock cycles. The programming length must be at least one page of cycles, because the commit walks the buffer one offset per cycle.

Top module: `pgw_load_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `page_err` is 0 and `rdata` is 0.
- R2: A write strobe is the rising edge of the condition `bus_sel`=1, `bus_wr`=1, `bus_rd`=0. If `bus_rd` is 1 while `bus_sel` and `bus_wr` are 1, no byte is loaded and no programming follows.
- R3: `busy` rises exactly `WINDOW_CYC` clock edges after the last write strobe of a load. A new strobe at or before that edge restarts the window.
- R4: Once `busy` is high it stays high for exactly `PROG_CYC` cycles and then falls.
- R5: Each loaded byte is committed to array address {latched page, addr[7:0]}. The page is the value of addr[ADDR_W-1:8] at the first strobe of the load. A load of a single byte is a valid load.
- R6: A later strobe in the same load whose page differs from the latched page is dropped, and it still restarts the window. It sets `page_err` one edge later. `page_err` stays 1 until the edge where `busy` falls, and is 0 from then on.
- R7: If the same offset is written twice in one load, the last value written is committed.
- R8: Offsets of the page that were not loaded keep their previous array contents.
- R9: Write strobes that arrive while `busy` is 1 have no effect on the array, on the load buffer or on the length of `busy`.
- R10: A read request is `bus_sel`=1, `bus_rd`=1, `bus_wr`=0. It loads `rdata` with array[addr] on the next edge. With no read request, `rdata` holds its value.
- R11: A load of all 256 offsets of a page commits all 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Device select, active high |
| bus_wr | input | 1 | Write request, active high |
| bus_rd | input | 1 | Read request, active high |
| addr | input | ADDR_W | Byte address: page in bits ADDR_W-1..8, offset in bits 7..0 |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High during the programming phase |
| page_err | output | 1 | Sticky flag for a dropped out-of-page byte |

## Verification
Each result is due a fixed number of edges after its stimulus:
- `page_err` and `rdata` change on the edge that samples the strobe or the read request.
- `busy` rises on the `WINDOW_CYC`-th edge after the last strobe of a load.
- `busy` falls `PROG_CYC` edges after it rose.

The bench drives inputs on falling edges and counts edges from the strobe, and it samples one half-cycle after the edge where a change is due. It also samples the edge before, where the old value must still hold. Array contents are checked through the normal read path once `busy` has fallen.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_timer.sv
// Down-counter: load starts a run of CYC cycles, expired flags the end.
module pgw_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic expired
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CYC - 1);
    end else if (en && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pgw_load_buf.sv
// Page load buffer: one data entry and one valid bit per in-page offset.
module pgw_load_buf #(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ofs] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_ofs] <= 1'b1;
    end
  end

  assign rd_data  = mem[rd_ofs];
  assign rd_valid = vld[rd_ofs];
endmodule

// File: rtl/pgw_array.sv
// Storage array: one write port, one registered read port.
module pgw_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/pgw_load_ctrl.sv
module pgw_load_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 8,
  parameter int WINDOW_CYC = 40,
  parameter int PROG_CYC   = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              page_err
);
  import pgw_pkg::*;

  localparam int PAGE_W = ADDR_W - OFS_W;

  pgw_state_e         state;
  logic               wcond, wprev, strobe;
  logic [PAGE_W-1:0]  page_q;
  logic               page_hit;
  logic [OFS_W:0]     walk;
  logic               walk_done;
  logic               win_exp, prog_exp;
  logic               buf_wr, buf_clr, buf_valid;
  logic [DATA_W-1:0]  buf_data;
  logic               arr_we, arr_re;
  logic               err_q;

  assign wcond     = bus_sel && bus_wr && !bus_rd;
  assign strobe    = wcond && !wprev;
  assign page_hit  = (addr[ADDR_W-1:OFS_W] == page_q);
  assign walk_done = walk[OFS_W];

  assign buf_wr  = strobe && ((state == ST_IDLE) || ((state == ST_LOAD) && page_hit));
  assign buf_clr = (state == ST_PROG) && prog_exp;
  assign arr_we  = (state == ST_PROG) && !walk_done && buf_valid;
  assign arr_re  = bus_sel && bus_rd && !bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wprev  <= 1'b0;
      page_q <= '0;
      walk   <= '0;
      err_q  <= 1'b0;
    end else begin
      wprev <= wcond;
      unique case (state)
        ST_IDLE: begin
          if (strobe) begin
            page_q <= addr[ADDR_W-1:OFS_W];
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (strobe) begin
            if (!page_hit) begin
              err_q <= 1'b1;
            end
          end else if (win_exp) begin
            state <= ST_PROG;
            walk  <= '0;
          end
        end
        ST_PROG: begin
          if (!walk_done) begin
            walk <= walk + 1'b1;
          end
          if (prog_exp) begin
            state <= ST_IDLE;
            err_q <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgw_timer #(.CYC(WINDOW_CYC)) win_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (strobe && (state != ST_PROG)),
    .en      (state == ST_LOAD),
    .expired (win_exp)
  );

  pgw_timer #(.CYC(PROG_CYC)) prog_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    ((state == ST_LOAD) && !strobe && win_exp),
    .en      (state == ST_PROG),
    .expired (prog_exp)
  );

  pgw_load_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) buf_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (buf_wr),
    .wr_ofs   (addr[OFS_W-1:0]),
    .wr_data  (wdata),
    .clr      (buf_clr),
    .rd_ofs   (walk[OFS_W-1:0]),
    .rd_data  (buf_data),
    .rd_valid (buf_valid)
  );

  pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .waddr ({page_q, walk[OFS_W-1:0]}),
    .wdata (buf_data),
    .re    (arr_re),
    .raddr (addr),
    .rdata (rdata)
  );

  assign busy     = (state == ST_PROG);
  assign page_err = err_q;
endmodule

// File: rtl/pgw_load_ctrl_chk.sv
module pgw_load_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int WINDOW_CYC = 40,
  parameter int PROG_CYC   = 300
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input logic              page_err
);
  logic prev_c;
  logic strobe_c;
  int   gap;
  int   blen;

  assign strobe_c = bus_sel && bus_wr && !bus_rd && !prev_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_c <= 1'b0;
      gap    <= WINDOW_CYC + 1;
      blen   <= 0;
    end else begin
      prev_c <= bus_sel && bus_wr && !bus_rd;
      if (strobe_c && !busy) begin
        gap <= 0;
      end else if (gap <= WINDOW_CYC) begin
        gap <= gap + 1;
      end
      if (busy) begin
        blen <= blen + 1;
      end else begin
        blen <= 0;
      end
    end
  end

  AST_WINDOW_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (gap == WINDOW_CYC)); // R3
  AST_PROG_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (blen == PROG_CYC)); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (page_err && busy) |=> (page_err || !busy)); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !page_err); // R6
  AST_ERR_RISE_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(page_err) |-> !busy); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_rd && !bus_wr) |=> $stable(rdata)); // R10
endmodule

bind pgw_load_ctrl pgw_load_ctrl_chk #(
  .DATA_W     (DATA_W),
  .WINDOW_CYC (WINDOW_CYC),
  .PROG_CYC   (PROG_CYC)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .rdata    (rdata),
  .busy     (busy),
  .page_err (page_err)
);

// File: tb/pgw_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgw_load_ctrl_tb_top;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int WIN = 12;
  localparam int PRG = 300;

  typedef struct packed {
    logic [1:0]    op;   // 0 write, 1 wait for programming, 2 read and compare
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 11'h203, 8'h11},
    '{2'd0, 11'h210, 8'h22},
    '{2'd0, 11'h203, 8'h33},
    '{2'd0, 11'h2FF, 8'h44},
    '{2'd1, 11'h000, 8'h00},
    '{2'd2, 11'h203, 8'h33},
    '{2'd2, 11'h210, 8'h22},
    '{2'd2, 11'h2FF, 8'h44},
    '{2'd0, 11'h300, 8'h5A},
    '{2'd1, 11'h000, 8'h00},
    '{2'd2, 11'h300, 8'h5A},
    '{2'd2, 11'h203, 8'h33}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          busy, page_err;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  pgw_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(8), .WINDOW_CYC(WIN), .PROG_CYC(PRG)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .page_err(page_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = a; bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    v = rdata;
  endtask

  task automatic wait_prog(input string req);
    int t;
    t = 0;
    while (!busy && t < 200) begin @(negedge clk); t++; end
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 page_err", {31'd0, page_err}, 32'd0);
    chk("R1 rdata", {24'd0, rdata}, 32'd0);

    // Table walk: page latch, repeated offset, single-byte load, read path
    for (int i = 0; i < 12; i++) begin
      case (VEC[i].op)
        2'd0: wr_byte(VEC[i].a, VEC[i].d);
        2'd1: wait_prog("R5 program end");
        default: begin
          rd_byte(VEC[i].a, v);
          chk("R5 R7 R10 table read", {24'd0, v}, {24'd0, VEC[i].d});
        end
      endcase
    end

    // R11: full page of page 1
    for (int i = 0; i < 256; i++) wr_byte(11'h100 | AW'(i), DW'(i) ^ 8'h5A);
    wait_prog("R11 program end");
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      rd_byte(11'h100 | AW'(i), v);
      if (v !== (DW'(i) ^ 8'h5A)) bad++;
    end
    chk("R11 full page mismatches", bad, 0);

    // R3 window timing with extension, R4 length, R9 ignored strobe, R8 untouched bytes
    wr_byte(11'h103, 8'hC3);
    repeat (WIN - 2) @(negedge clk);
    chk("R3 no busy inside window", {31'd0, busy}, 32'd0);
    wr_byte(11'h107, 8'hC7);
    repeat (WIN - 1) @(negedge clk);
    chk("R3 busy low one edge before window end", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R3 busy high at window end", {31'd0, busy}, 32'd1);
    repeat (10) @(negedge clk);
    wr_byte(11'h104, 8'hEE);
    repeat (PRG - 1 - 12) @(negedge clk);
    chk("R4 busy high on last program cycle", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R4 busy low after program length", {31'd0, busy}, 32'd0);
    rd_byte(11'h103, v); chk("R8 loaded offset 3", {24'd0, v}, 32'hC3);
    rd_byte(11'h107, v); chk("R8 loaded offset 7", {24'd0, v}, 32'hC7);
    rd_byte(11'h104, v); chk("R9 strobe during busy ignored", {24'd0, v}, {24'd0, 8'h04 ^ 8'h5A});
    rd_byte(11'h105, v); chk("R8 untouched offset kept", {24'd0, v}, {24'd0, 8'h05 ^ 8'h5A});
    repeat (WIN + 4) @(negedge clk);
    chk("R9 no second program from ignored strobe", {31'd0, busy}, 32'd0);

    // R6 page mismatch
    wr_byte(11'h601, 8'h99);
    wait_prog("R5 single byte program end");
    wr_byte(11'h500, 8'h11);
    chk("R6 no error on first byte", {31'd0, page_err}, 32'd0);
    wr_byte(11'h601, 8'h22);
    chk("R6 error set after mismatched strobe", {31'd0, page_err}, 32'd1);
    repeat (WIN) @(negedge clk);
    chk("R6 window restarted by dropped strobe", {31'd0, busy}, 32'd1);
    chk("R6 error held while busy", {31'd0, page_err}, 32'd1);
    wait_prog("R6 program end");
    chk("R6 error cleared after program", {31'd0, page_err}, 32'd0);
    rd_byte(11'h500, v); chk("R6 in-page byte committed", {24'd0, v}, 32'h11);
    rd_byte(11'h601, v); chk("R6 dropped byte not written", {24'd0, v}, 32'h99);

    // R2 write with read also active is not a write
    @(negedge clk);
    addr = 11'h500; wdata = 8'hFF; bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (WIN + 4) @(negedge clk);
    chk("R2 no program after blocked write", {31'd0, busy}, 32'd0);
    rd_byte(11'h500, v); chk("R2 array unchanged", {24'd0, v}, 32'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule